// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block gathers five interrupt sources and picks at most one of them to present to a processor core as a vector address. The sources are two active-low external request pins, two timer overflow flags and one serial flag. The serial flag is the OR of a receive flag and a transmit flag. The core loads three small configuration registers through a write port. The first holds a master enable and one enable per source. The second holds one priority bit per source. The third selects, for each external pin, between level and falling-edge triggering.

Each source sits on one of two priority levels. The arbiter keeps one in-service bit per level, and uses them to decide whether a waiting request may interrupt the routine that is running. The core reports that it has jumped to the presented vector by pulsing `vec_take`, and that a routine has returned by pulsing `reti`. The block answers a take with a registered acknowledge pulse that carries the source as a one-hot code. On the take it also clears the flags that hardware is supposed to clear. The external pins are sampled only when `mc_strobe` marks the sampling point of a machine cycle.

Top module: `irq_arbiter`

## Requirements
- R1: After reset all enables, priorities and trigger modes are 0, no level is in service, and `irq_req` and `irq_ack` are 0.
- R2: A request is presented only when the master enable (bit 5 of register 0) is 1 and the source's own enable bit (bit i of register 0) is 1. Source index i is 0 for external 0, 1 for timer 0, 2 for external 1, 3 for timer 1 and 4 for serial.
- R3: Bit i of register 1 set to 1 puts source i on the high level. When both levels have pending requests, a high-level source is presented and `irq_level` is 1.
- R4: Among pending requests on the same level, the source with the lowest index is presented.
- R5: `irq_vector` is 0x0003 + 8·i for the presented source i, giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R6: While a low-level routine is in service, a high-level request is presented and a low-level request is not.
- R7: While a high-level routine is in service, no request is presented.
- R8: With bit g of register 2 at 0 (level mode), the flag of external g takes the inverted pin value at each `mc_strobe`, does not change between strobes, and is not cleared by a take.
- R9: With bit g of register 2 at 1 (edge mode), the flag of external g is set when one strobe samples the pin high and the next strobe samples it low. A take of that source clears the flag.
- R10: A timer overflow pulse sets that timer's flag, and a take of that timer clears it.
- R11: The serial request is the OR of `ser_rx_flag` and `ser_tx_flag`, and a take never clears it.
- R12: Once a take is accepted, no further request is presented until the next `mc_strobe`. A `vec_take` while `irq_req` is 0 has no effect.
- R13: A `reti` clears the high in-service bit if it is set, and otherwise clears the low one.
- R14: The cycle after an accepted take, `irq_ack` is 1 for one cycle and `ack_src` is the one-hot code of the taken source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_strobe | input | 1 | Machine-cycle sampling strobe |
| ext_req_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Register select: 0 enables, 1 priority, 2 trigger mode |
| cfg_wdata | input | 6 | Configuration write data |
| vec_take | input | 1 | Core has taken the presented vector |
| reti | input | 1 | Return from interrupt |
| irq_req | output | 1 | Request presented to the core |
| irq_level | output | 1 | Level of the presented request |
| irq_vector | output | 16 | Vector address of the presented request |
| irq_ack | output | 1 | Acknowledge pulse |
| ack_src | output | 5 | One-hot source of the acknowledged take |

## Verification
The bench builds the block with its default parameters, a vector base of 0x0003 and a stride of 8. With these values every entry of the five-entry vector table can be compared with a fixed expected address. The machine-cycle strobe is driven by hand, separate from the clock. This makes it possible to check the cycles between strobes: level flags holding, the one-take-per-cycle block, and late high-level requests that must wait for the next strobe. Nested sequences move the block through three states: low in service, high in service, and both.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int              VEC_W      = 16,
  parameter logic [15:0]     VEC_BASE   = 16'h0003,
  parameter int              VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_strobe,
  input  logic [1:0]       ext_req_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_rx_flag,
  input  logic             ser_tx_flag,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [5:0]       cfg_wdata,
  input  logic             vec_take,
  input  logic             reti,
  output logic             irq_req,
  output logic             irq_level,
  output logic [VEC_W-1:0] irq_vector,
  output logic             irq_ack,
  output logic [4:0]       ack_src
);
  localparam int NSRC  = 5;
  localparam int NEXT  = 2;
  localparam int IDX_W = $clog2(NSRC);
  localparam int GLB   = NSRC;

  logic [NSRC-1:0] en_src, pri;
  logic            en_glb;
  logic [NEXT-1:0] edge_mode, ext_prev, ext_flag, tmr_flag;
  logic            ins_hi, ins_lo, taken_mc;

  logic [NSRC-1:0] raw, pend, hi_set, lo_set, win_oh;
  logic [IDX_W-1:0] hi_idx, lo_idx, win_idx;
  logic            hi_any, lo_any, found, take_ok;

  assign raw    = {ser_rx_flag | ser_tx_flag, tmr_flag[1], ext_flag[1], tmr_flag[0], ext_flag[0]};
  assign pend   = raw & en_src & {NSRC{en_glb}};
  assign hi_set = pend & pri;
  assign lo_set = pend & ~pri;

  always_comb begin
    hi_idx = '0; hi_any = 1'b0;
    lo_idx = '0; lo_any = 1'b0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (hi_set[i]) begin hi_idx = IDX_W'(i); hi_any = 1'b1; end
      if (lo_set[i]) begin lo_idx = IDX_W'(i); lo_any = 1'b1; end
    end
  end

  assign irq_level  = hi_any & ~ins_hi;
  assign found      = irq_level | (lo_any & ~ins_hi & ~ins_lo);
  assign win_idx    = irq_level ? hi_idx : lo_idx;
  assign win_oh     = NSRC'(1) << win_idx;
  assign irq_req    = found & ~taken_mc;
  assign take_ok    = vec_take & irq_req;
  assign irq_vector = VEC_BASE + VEC_W'(win_idx) * VEC_W'(VEC_STRIDE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_src <= '0; en_glb <= 1'b0; pri <= '0; edge_mode <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin en_src <= cfg_wdata[NSRC-1:0]; en_glb <= cfg_wdata[GLB]; end
        2'd1: pri <= cfg_wdata[NSRC-1:0];
        2'd2: edge_mode <= cfg_wdata[NEXT-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    logic pin, edge_set, edge_clr, tmr_clr;
    assign pin      = ext_req_n[g];
    assign edge_set = mc_strobe & edge_mode[g] & ext_prev[g] & ~pin;
    assign edge_clr = take_ok & win_oh[2*g] & edge_mode[g];
    assign tmr_clr  = take_ok & win_oh[2*g+1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ext_prev[g] <= 1'b1;
        ext_flag[g] <= 1'b0;
        tmr_flag[g] <= 1'b0;
      end else begin
        if (mc_strobe) ext_prev[g] <= pin;
        if (mc_strobe && !edge_mode[g]) ext_flag[g] <= ~pin;
        else if (edge_set)              ext_flag[g] <= 1'b1;
        else if (edge_clr)              ext_flag[g] <= 1'b0;
        if (tmr_ovf[g])   tmr_flag[g] <= 1'b1;
        else if (tmr_clr) tmr_flag[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_hi <= 1'b0; ins_lo <= 1'b0; taken_mc <= 1'b0;
      irq_ack <= 1'b0; ack_src <= '0;
    end else begin
      if (reti && ins_hi)      ins_hi <= 1'b0;
      else if (reti)           ins_lo <= 1'b0;
      if (take_ok && irq_level)  ins_hi <= 1'b1;
      if (take_ok && !irq_level) ins_lo <= 1'b1;
      if (take_ok)        taken_mc <= 1'b1;
      else if (mc_strobe) taken_mc <= 1'b0;
      irq_ack <= take_ok;
      ack_src <= take_ok ? win_oh : '0;
    end
  end

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_glb && en_src[win_idx]));
  p_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector[2:0] == 3'd3 && irq_vector <= VEC_BASE + VEC_W'(4*VEC_STRIDE)));
  p_lo_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_lo && irq_req) |-> pri[win_idx]);
  p_hi_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |-> !irq_req);
  p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_strobe && !edge_mode[0]) |=> (ext_flag[0] == !$past(ext_req_n[0])));
  p_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_strobe && edge_mode[1] && ext_prev[1] && !ext_req_n[1]) |=> ext_flag[1]);
  p_tmr_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ok && win_idx == 3'd1 && !tmr_ovf[0]) |=> !tmr_flag[0]);
  p_ser_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && win_idx == 3'd4) |-> (ser_rx_flag || ser_tx_flag));
  p_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_take && irq_req) |=> !irq_req);
  p_reti_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && ins_hi) |=> !ins_hi);
  p_ack_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_take && irq_req) |=> (irq_ack && $countones(ack_src) == 1));
endmodule

// File: tb/irq_arbiter_tb_top.sv
module irq_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_strobe = 1'b0;
  logic [1:0] ext_req_n = 2'b11;
  logic [1:0] tmr_ovf = 2'b00;
  logic ser_rx_flag = 1'b0, ser_tx_flag = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [5:0] cfg_wdata = 6'd0;
  logic vec_take = 1'b0, reti = 1'b0;
  logic irq_req, irq_level, irq_ack;
  logic [15:0] irq_vector;
  logic [4:0] ack_src;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  irq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe), .ext_req_n(ext_req_n),
    .tmr_ovf(tmr_ovf), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .vec_take(vec_take), .reti(reti), .irq_req(irq_req), .irq_level(irq_level),
    .irq_vector(irq_vector), .irq_ack(irq_ack), .ack_src(ack_src));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_req_n = 2'b11; tmr_ovf = '0; ser_rx_flag = 0; ser_tx_flag = 0;
    mc_strobe = 0; vec_take = 0; reti = 0; cfg_we = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; @(negedge clk); cfg_we = 0;
  endtask
  task automatic strobe();  mc_strobe = 1; @(negedge clk); mc_strobe = 0; endtask
  task automatic take();    vec_take = 1;  @(negedge clk); vec_take = 0;  endtask
  task automatic ret();     reti = 1;      @(negedge clk); reti = 0;      endtask
  task automatic ovf(input int t); tmr_ovf[t] = 1; @(negedge clk); tmr_ovf = '0; endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req", irq_req, 0);
    chk("R1 ack", irq_ack, 0);
    ovf(0);
    chk("R1 enables clear", irq_req, 0);
  endtask

  task automatic t_gate();
    do_reset();
    ovf(0);
    wr(0, 6'h02);
    chk("R2 no master", irq_req, 0);
    wr(0, 6'h20);
    chk("R2 no source enable", irq_req, 0);
    wr(0, 6'h28);
    chk("R2 other source only", irq_req, 0);
    wr(0, 6'h22);
    chk("R2 enabled req", irq_req, 1);
    chk("R2 vector", irq_vector, 16'h000B);
  endtask

  task automatic t_prio();
    do_reset();
    wr(0, 6'h3F); wr(1, 6'h08);
    tmr_ovf = 2'b11; @(negedge clk); tmr_ovf = '0;
    chk("R3 req", irq_req, 1);
    chk("R3 level", irq_level, 1);
    chk("R3 vector", irq_vector, 16'h001B);
  endtask

  task automatic t_order();
    do_reset();
    wr(0, 6'h3F);
    tmr_ovf = 2'b11; ser_tx_flag = 1; @(negedge clk); tmr_ovf = '0;
    chk("R4 first timer0", irq_vector, 16'h000B);
    chk("R4 level low", irq_level, 0);
    take(); ret(); strobe();
    chk("R4 then timer1", irq_vector, 16'h001B);
    chk("R10 timer0 cleared", irq_req, 1);
    take(); ret(); strobe();
    chk("R5 serial vector", irq_vector, 16'h0023);
  endtask

  task automatic t_nest();
    do_reset();
    wr(0, 6'h3F); wr(1, 6'h08);
    ovf(0);
    chk("R5 timer0 vector", irq_vector, 16'h000B);
    take();
    chk("R14 ack", irq_ack, 1);
    chk("R14 ack_src", ack_src, 5'b00010);
    @(negedge clk);
    chk("R14 ack one cycle", irq_ack, 0);
    strobe();
    ser_rx_flag = 1; @(negedge clk);
    chk("R6 low blocked", irq_req, 0);
    ovf(1);
    chk("R6 high preempts", irq_req, 1);
    chk("R6 vector", irq_vector, 16'h001B);
    take();
    chk("R14 ack_src timer1", ack_src, 5'b01000);
    strobe();
    wr(1, 6'h0A); ovf(0);
    chk("R7 high blocked", irq_req, 0);
    ret();
    chk("R13 high cleared first", irq_req, 1);
    chk("R13 vector", irq_vector, 16'h000B);
    take(); strobe(); ret();
    chk("R13 low still in service", irq_req, 0);
    ret();
    chk("R13 low cleared", irq_req, 1);
    chk("R11 serial vector", irq_vector, 16'h0023);
    take(); strobe(); ret();
    chk("R11 not cleared", irq_req, 1);
    ser_rx_flag = 0; @(negedge clk);
    chk("R11 serial gone", irq_req, 0);
  endtask

  task automatic t_level();
    do_reset();
    wr(0, 6'h21);
    ext_req_n[0] = 0; @(negedge clk);
    chk("R8 waits for strobe", irq_req, 0);
    strobe();
    chk("R8 req", irq_req, 1);
    chk("R8 vector", irq_vector, 16'h0003);
    take(); ret(); strobe();
    chk("R8 not cleared by take", irq_req, 1);
    ext_req_n[0] = 1; @(negedge clk);
    chk("R8 holds between strobes", irq_req, 1);
    strobe();
    chk("R8 follows pin", irq_req, 0);
  endtask

  task automatic t_edge();
    do_reset();
    wr(0, 6'h24); wr(2, 6'h02);
    strobe();
    ext_req_n[1] = 0; strobe();
    chk("R9 edge sets", irq_req, 1);
    chk("R9 vector", irq_vector, 16'h0013);
    take(); ret(); strobe();
    chk("R9 cleared by take", irq_req, 0);
    strobe();
    chk("R9 low level no retrigger", irq_req, 0);
    ext_req_n[1] = 1; strobe();
    ext_req_n[1] = 0; strobe();
    chk("R9 second edge", irq_req, 1);
  endtask

  task automatic t_once();
    do_reset();
    wr(0, 6'h3F); wr(1, 6'h08);
    ovf(0); take();
    ovf(1);
    chk("R12 blocked in same cycle", irq_req, 0);
    take();
    chk("R12 stray take ignored", irq_ack, 0);
    strobe();
    chk("R12 next cycle req", irq_req, 1);
    chk("R12 vector", irq_vector, 16'h001B);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_gate();
    t_prio();
    t_order();
    t_nest();
    t_level();
    t_edge();
    t_once();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule